// File: doc/BRIEF.md
# Serialising Word FIFO

This block buffers parallel words and plays them back one bit per shift request. A producer pushes 16-bit words through a single-cycle write enable. A consumer pulls a serial stream through a single-cycle shift enable. One system clock drives the whole block.

The bit order within each word is fixed while reset is held. It stays fixed until the next reset. Four active-low level flags report the occupancy: full, empty, more-than-half, and a combined outer-band flag. The outer-band flag is asserted near either end of the buffer. The storage depth is a parameter (256, 512 or 1024 words).

A word keeps its slot until its last bit has left. Occupancy therefore changes only on whole-word boundaries.

Top module: `piso_fifo`

## Requirements
- R1: While `rst_n` is low, the write and read positions return to the first slot. Any stored words are discarded. The first word written after reset is the first word shifted out.
- R2: During and right after reset, the flags are `full_n`=1, `half_n`=1, `empty_n`=0 and `band_n`=0, and `ser_out`=0.
- R3: `msb_first` is sampled only while `rst_n` is low. Value 1 sends bit 15 first and bit 0 last. Value 0 sends bit 0 first and bit 15 last. Changes after reset have no effect.
- R4: When `full_n` is 0, a `wr_en` pulse stores nothing and leaves the contents and flags unchanged.
- R5: When `empty_n` is 0, a `shift_en` pulse has no effect, and `ser_out` stays 0.
- R6: `full_n` is 0 exactly when the stored word count equals DEPTH.
- R7: `empty_n` is 0 exactly when the stored word count is 0. A word counts as stored until all 16 of its bits have been shifted out.
- R8: `half_n` is 0 exactly when the count is greater than DEPTH/2.
- R9: `band_n` is 1 exactly when DEPTH/8 <= count <= 7*DEPTH/8. It is 0 otherwise.
- R10: Words leave in the order they were written. Writes are accepted while a word is being shifted out.
- R11: If a write and the shift of a word's final bit fall in the same cycle, the count is unchanged.
- R12: `ser_out` takes the new bit at the clock edge where an accepted `shift_en` is sampled, and holds it otherwise. At any edge where the buffer is empty and no shift is accepted, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| msb_first | input | 1 | Bit-order select, sampled during reset |
| wr_en | input | 1 | Single-cycle word write request |
| wr_data | input | 16 | Word to store |
| shift_en | input | 1 | Single-cycle serial shift request |
| ser_out | output | 1 | Current serial bit |
| full_n | output | 1 | Low when DEPTH words are stored |
| empty_n | output | 1 | Low when no words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| band_n | output | 1 | Low below DEPTH/8 or above 7*DEPTH/8 words |

## Verification
Every result is due at the rising edge that samples the request. The occupancy register moves on that edge. The four flags are decoded from it with no further register, so they are valid after the same edge, and `ser_out` is updated on that edge too. The bench drives its inputs on the falling edge and samples 1 ns after the next rising edge. It then advances its own queue model by exactly one edge and compares every output in that cycle, so any extra or missing register stage shows up as a mismatch.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // occupancy decodes, shared with the level tracker
  function automatic logic is_full(input int unsigned cnt, input int unsigned depth);
    return cnt == depth;
  endfunction

  function automatic logic is_empty(input int unsigned cnt);
    return cnt == 0;
  endfunction

  function automatic logic over_half(input int unsigned cnt, input int unsigned depth);
    return cnt > depth / 2;
  endfunction

  // 1 inside the middle band [depth/8, 7*depth/8]
  function automatic logic in_band(input int unsigned cnt, input int unsigned depth);
    return (cnt >= depth / 8) && (cnt <= (7 * depth) / 8);
  endfunction

  // position in the word of the bit sent at step idx
  function automatic int unsigned bit_pos(input int unsigned idx, input logic msb,
                                          input int unsigned width);
    return msb ? (width - 1 - idx) : idx;
  endfunction

endpackage

// File: rtl/piso_store.sv
module piso_store #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          full_n,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          wr_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;

  assign wr_ok   = wr_en & full_n & rst_n;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     wptr <= '0;
    else if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
  end

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full_n) |=> $stable(wptr)); // R4

endmodule

// File: rtl/piso_serializer.sv
module piso_serializer #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msb_first,
  input  logic          shift_en,
  input  logic          empty_n,
  input  logic [W-1:0]  rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          word_done,
  output logic          ser_out
);
  logic          dir_q;
  logic [BW-1:0] bidx;
  logic [BW-1:0] sel;
  logic          shift_ok;

  assign shift_ok  = shift_en & empty_n;
  assign word_done = shift_ok & (bidx == BW'(W - 1));
  assign sel       = BW'(piso_pkg::bit_pos(32'(bidx), dir_q, W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= msb_first;
      bidx    <= '0;
      rd_addr <= '0;
      ser_out <= 1'b0;
    end else if (shift_ok) begin
      ser_out <= rd_data[sel];
      if (bidx == BW'(W - 1)) begin
        bidx    <= '0;
        rd_addr <= (rd_addr == AW'(DEPTH - 1)) ? '0 : rd_addr + AW'(1);
      end else begin
        bidx <= bidx + BW'(1);
      end
    end else if (!empty_n) begin
      ser_out <= 1'b0;
    end
  end

  AST_EMPTY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !empty_n) |=> ($stable(rd_addr) && $stable(bidx))); // R5
  AST_EMPTY_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> !ser_out); // R12
  AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(dir_q)); // R3

endmodule

// File: rtl/piso_level.sv
module piso_level #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          word_done,
  output logic [CW-1:0] count,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          band_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     count <= '0;
    else if (wr_ok && !word_done)   count <= count + CW'(1);
    else if (word_done && !wr_ok)   count <= count - CW'(1);
  end

  always_comb begin
    full_n  = ~piso_pkg::is_full(32'(count), DEPTH);
    empty_n = ~piso_pkg::is_empty(32'(count));
    half_n  = ~piso_pkg::over_half(32'(count), DEPTH);
    band_n  =  piso_pkg::in_band(32'(count), DEPTH);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && word_done) |=> $stable(count)); // R11
  AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> (!band_n && half_n && full_n)); // R9

endmodule

// File: rtl/piso_fifo.sv
module piso_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msb_first,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         shift_en,
  output logic         ser_out,
  output logic         full_n,
  output logic         empty_n,
  output logic         half_n,
  output logic         band_n
);
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data;
  logic          wr_ok;
  logic          word_done;
  logic [CW-1:0] count;

  piso_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .full_n(full_n),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ok(wr_ok)
  );

  piso_serializer #(.W(W), .DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst_n(rst_n), .msb_first(msb_first), .shift_en(shift_en),
    .empty_n(empty_n), .rd_data(rd_data), .rd_addr(rd_addr),
    .word_done(word_done), .ser_out(ser_out)
  );

  piso_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .word_done(word_done),
    .count(count), .full_n(full_n), .empty_n(empty_n),
    .half_n(half_n), .band_n(band_n)
  );

  AST_WORD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (count != '0)); // R7
  AST_RESET_FLAGS: assert property (@(posedge clk)
    !rst_n |=> (!empty_n && full_n && half_n && !band_n)); // R2

endmodule

// File: tb/test_piso_fifo.sv
`timescale 1ns/1ps
module test_piso_fifo;
  localparam int DEPTH = 256;
  localparam int W     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msb_first = 1'b0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic shift_en = 1'b0;
  logic ser_out, full_n, empty_n, half_n, band_n;

  always #2 clk = ~clk;

  piso_fifo #(.W(W), .DEPTH(DEPTH)) i_piso_fifo (
    .clk(clk), .rst_n(rst_n), .msb_first(msb_first), .wr_en(wr_en),
    .wr_data(wr_data), .shift_en(shift_en), .ser_out(ser_out),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .band_n(band_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] mdl_mem [DEPTH];
  int  m_head, m_tail, m_cnt, m_bit;
  logic m_dir, m_so;
  string so_tag = "R10";

  function automatic logic exp_full(int c);  return !(c == DEPTH); endfunction
  function automatic logic exp_empty(int c); return c != 0; endfunction
  function automatic logic exp_half(int c);  return !(2 * c > DEPTH); endfunction
  function automatic logic exp_band(int c);
    return (8 * c >= DEPTH) && (8 * c <= 7 * DEPTH);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (count %0d)", tag, what, act, exp, m_cnt);
    end
  endtask

  task automatic check_all();
    chk(ser_out, m_so, so_tag, "ser_out");
    chk(full_n,  exp_full(m_cnt),  "R6", "full_n");
    chk(empty_n, exp_empty(m_cnt), "R7", "empty_n");
    chk(half_n,  exp_half(m_cnt),  "R8", "half_n");
    chk(band_n,  exp_band(m_cnt),  "R9", "band_n");
  endtask

  task automatic do_reset(input logic dir);
    @(negedge clk);
    rst_n = 1'b0; msb_first = dir; wr_en = 1'b0; shift_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    m_head = 0; m_tail = 0; m_cnt = 0; m_bit = 0; m_so = 1'b0; m_dir = dir;
    chk(ser_out, 1'b0, "R2", "ser_out in reset");
    chk(full_n, 1'b1, "R2", "full_n in reset");
    chk(half_n, 1'b1, "R2", "half_n in reset");
    chk(empty_n, 1'b0, "R2", "empty_n in reset");
    chk(band_n, 1'b0, "R2", "band_n in reset");
    @(negedge clk);
    rst_n = 1'b1;
    msb_first = ~dir;  // R3: must be ignored from here on
  endtask

  task automatic step(input logic wr, input logic [W-1:0] d, input logic sh);
    logic wok, sok;
    logic [W-1:0] w;
    @(negedge clk);
    wr_en = wr; wr_data = d; shift_en = sh;
    @(posedge clk);
    #1;
    wok = wr && (m_cnt != DEPTH);
    sok = sh && (m_cnt != 0);
    if (sok) begin
      w = mdl_mem[m_head];
      m_so = m_dir ? w[W-1-m_bit] : w[m_bit];
      m_bit++;
      if (m_bit == W) begin
        m_bit = 0;
        m_head = (m_head + 1) % DEPTH;
        m_cnt--;
      end
    end else if (m_cnt == 0) begin
      m_so = 1'b0;
    end
    if (wok) begin
      mdl_mem[m_tail] = d;
      m_tail = (m_tail + 1) % DEPTH;
      m_cnt++;
    end
    check_all();
    wr_en = 1'b0; shift_en = 1'b0;
  endtask

  task automatic rand_block(input int cycles, input int wp, input int sp);
    for (int i = 0; i < cycles; i++) begin
      logic wr, sh;
      wr = ($urandom % 100) < wp;
      sh = ($urandom % 100) < sp;
      so_tag = (wr && sh && m_bit == W - 1 && m_cnt != 0 && m_cnt != DEPTH) ? "R11" : "R10";
      step(wr, W'($urandom), sh);
    end
    so_tag = "R10";
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset(1'b0);

    // R1/R3: LSB-first word right after reset, dir pin now toggled
    so_tag = "R3";
    step(1'b1, 16'hA5C3, 1'b0);
    for (int i = 0; i < W; i++) step(1'b0, '0, 1'b1);

    // R5: shifting while empty does nothing
    so_tag = "R5";
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
    chk(empty_n, 1'b0, "R5", "empty after idle shifts");

    // fill to full, crossing every threshold
    so_tag = "R10";
    for (int i = 0; i < DEPTH; i++) step(1'b1, W'($urandom), 1'b0);
    chk(full_n, 1'b0, "R6", "full after DEPTH writes");

    // R4: writes while full are dropped
    so_tag = "R4";
    for (int i = 0; i < 4; i++) step(1'b1, 16'hDEAD, 1'b0);
    chk(full_n, 1'b0, "R4", "still full");

    // R7: partial word keeps its slot
    for (int i = 0; i < W - 1; i++) step(1'b0, '0, 1'b1);
    chk(full_n, 1'b0, "R7", "full with partly shifted word");
    so_tag = "R10";
    step(1'b0, '0, 1'b1);

    // R11: write on the last bit of a word
    for (int i = 0; i < W - 1; i++) step(1'b0, '0, 1'b1);
    so_tag = "R11";
    step(1'b1, 16'h1357, 1'b1);
    chk(full_n, 1'b1, "R11", "count held at DEPTH-1");

    // random traffic at several fill tendencies
    for (int r = 0; r < 2; r++) begin
      rand_block(3000, 70, 40);
      rand_block(4000, 4, 95);
      rand_block(4000, 7, 90);
    end

    // R1: reset with stored words empties the buffer; R3: MSB-first
    step(1'b1, 16'h0F0F, 1'b0);
    do_reset(1'b1);
    chk(empty_n, 1'b0, "R1", "reset discards contents");
    so_tag = "R1";
    step(1'b1, 16'h8001, 1'b0);
    step(1'b1, 16'h4C2E, 1'b0);
    so_tag = "R3";
    for (int i = 0; i < 2 * W; i++) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    so_tag = "R12";
    step(1'b1, 16'hFFFF, 1'b0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    rand_block(3000, 8, 85);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule